// File: doc/BRIEF.md
# Asynchronous Serial Transmitter/Receiver with Bit-Rate Generator

This block is a full-duplex asynchronous serial port. A shared bit-rate generator produces a sampling tick at sixteen times the bit rate. It is set by a two-bit prescaler code and an 8-bit divisor. The transmitter takes one byte at a time through a valid/ready handshake and serialises it. The receiver hunts for start bits, samples each bit at its centre and presents the received character.

Static configuration inputs shape the frame and apply to both directions:

- a 7- or 8-bit character;
- an optional even or odd parity bit, or in its place a multiprocessor bit that marks a character as an address or as data;
- one or two transmitted stop bits.

The receiver keeps sticky framing, parity, overrun and break flags until a clear pulse. The surrounding logic consumes a received character with a one-cycle read pulse.

Top module: `async_serial_ctrl`

## Requirements
- R1: After reset txd_o is high, tx_ready_o is high, rx_valid_o is low and fer_o, per_o, oer_o and brk_o are low.
- R2: The sampling tick period is 2 × 4^presc_sel_i × (divisor_i + 1) clock cycles, and one bit lasts 16 ticks. presc_sel_i = 0, 1, 2, 3 gives a prescale of 1, 4, 16, 64.
- R3: A transmitted frame is one low start bit, then the data bits LSB first, then a high stop bit. With data7_i = 1 only tx_data_i[6:0] is sent; with data7_i = 0 all 8 bits are sent.
- R4: With parity_en_i = 1 and mp_en_i = 0, a parity bit follows the data. parity_odd_i = 0 makes the count of ones in data plus parity even; parity_odd_i = 1 makes it odd.
- R5: With mp_en_i = 1, the bit after the data is tx_mpb_i instead of parity. On receive that bit is presented on rx_mpb_o.
- R6: With stop2_i = 1 two high stop bits are sent, and tx_ready_o stays low until the second one ends. With stop2_i = 0, tx_ready_o returns high after the single stop bit.
- R7: A byte is accepted in a cycle where tx_valid_i and tx_ready_o are both high. In the next cycle tx_ready_o is low and txd_o is low.
- R8: A falling edge on rxd_i that is still low at the 8th tick is taken as a start bit. The character then appears on rx_data_o (upper bit 0 in 7-bit mode) with rx_valid_o high, and rx_valid_o drops in the cycle after a rx_read_i pulse.
- R9: A low pulse on rxd_i that is gone by the start-bit centre produces no character.
- R10: A first stop bit sampled low sets fer_o.
- R11: A received parity bit that does not match the configured sense sets per_o.
- R12: A character whose data bits, parity or multiprocessor bit (if present) and stop bit are all low sets brk_o, and also fer_o.
- R13: A character that completes while rx_valid_o is still high sets oer_o. The new character is discarded and rx_data_o keeps the earlier value.
- R14: fer_o, per_o, oer_o and brk_o stay set until a clr_err_i pulse, which clears all four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_sel_i | input | 2 | Prescaler code (divide by 4^code) |
| divisor_i | input | 8 | Bit-rate divisor minus one |
| data7_i | input | 1 | 1: 7-bit characters, 0: 8-bit |
| parity_en_i | input | 1 | Append/check a parity bit |
| parity_odd_i | input | 1 | 1: odd parity, 0: even |
| mp_en_i | input | 1 | Multiprocessor bit in place of parity |
| stop2_i | input | 1 | Transmit two stop bits |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmitter idle, can accept |
| tx_data_i | input | 8 | Byte to transmit |
| tx_mpb_i | input | 1 | Multiprocessor bit to transmit |
| txd_o | output | 1 | Serial output line |
| rxd_i | input | 1 | Serial input line |
| rx_valid_o | output | 1 | Unread received character present |
| rx_data_o | output | 8 | Received character |
| rx_mpb_o | output | 1 | Received multiprocessor bit |
| rx_read_i | input | 1 | Consume the received character |
| fer_o | output | 1 | Sticky framing error |
| per_o | output | 1 | Sticky parity error |
| oer_o | output | 1 | Sticky overrun error |
| brk_o | output | 1 | Sticky break detected |
| clr_err_i | input | 1 | Clear all sticky flags |

## Verification
The bench builds the block with its default widths: an 8-bit divisor and a 2-bit prescaler code. Most scenarios use prescale code 0 and divisor 0, which gives a 32-cycle bit, so every frame format, error case and overrun fits in a few hundred cycles. Two further transmissions use prescale code 1 with divisor 1, and prescale code 3 with divisor 0. These show that the bit period scales with both the divisor and the power-of-four prescaler, including the largest prescale.

// File: rtl/async_serial_pkg.sv
package async_serial_pkg;

  localparam int FRAME_MAX = 12;

  typedef struct packed {
    logic data7;
    logic par_en;
    logic par_odd;
    logic mp_en;
    logic stop2;
  } frame_cfg_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  // parity bit value for the active data bits
  function automatic logic par_bit(input logic [7:0] d, input logic d7, input logic odd);
    logic [7:0] m;
    m = d7 ? {1'b0, d[6:0]} : d;
    return (^m) ^ odd;
  endfunction

endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W  = 8,
  parameter int PSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic [DIV_W-1:0]  divisor_i,
  output logic              tick_o
);
  localparam int PRE_W = 2 * (2**PSEL_W - 1) + 1;

  logic [PRE_W:0]   pre_span;
  logic [PRE_W-1:0] pre_last;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_end;

  // span = 2 * 4^psel
  assign pre_span = {{PRE_W{1'b0}}, 1'b1} << {psel_i, 1'b1};
  assign pre_last = PRE_W'(pre_span - 1'b1);
  assign pre_end  = (pre_cnt >= pre_last);
  assign tick_o   = pre_end && (div_cnt >= divisor_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      if (pre_end) begin
        pre_cnt <= '0;
        if (div_cnt >= divisor_i) div_cnt <= '0;
        else                      div_cnt <= div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_serial_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  frame_cfg_t cfg_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  input  logic       mpb_i,
  output logic       ready_o,
  output logic       txd_o
);
  logic                 busy;
  logic [FRAME_MAX-1:0] sh;
  logic [FRAME_MAX-1:0] frame;
  logic [3:0]           bits_left;
  logic [3:0]           tick_cnt;
  logic [3:0]           dlen;
  logic [3:0]           nbits;
  logic                 extra;
  logic                 xbit;

  always_comb begin
    dlen  = cfg_i.data7 ? 4'd7 : 4'd8;
    extra = cfg_i.par_en | cfg_i.mp_en;
    xbit  = cfg_i.mp_en ? mpb_i : par_bit(data_i, cfg_i.data7, cfg_i.par_odd);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(dlen)) frame[i+1] = data_i[i];
    end
    if (extra) frame[dlen + 4'd1] = xbit;
    nbits = 4'd2 + dlen + {3'b0, extra} + {3'b0, cfg_i.stop2};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy      <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      tick_cnt  <= '0;
    end else if (!busy) begin
      if (valid_i) begin
        busy      <= 1'b1;
        sh        <= frame;
        bits_left <= nbits;
        tick_cnt  <= '0;
      end
    end else if (tick_i) begin
      tick_cnt <= tick_cnt + 4'd1;
      if (tick_cnt == 4'd15) begin
        sh        <= {1'b1, sh[FRAME_MAX-1:1]};
        bits_left <= bits_left - 4'd1;
        if (bits_left == 4'd1) busy <= 1'b0;
      end
    end
  end

  assign ready_o = !busy;
  assign txd_o   = busy ? sh[0] : 1'b1;

  p_accept_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !txd_o && !ready_o);

  p_bits_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (bits_left != 4'd0) && (bits_left <= 4'(FRAME_MAX)));

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_serial_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       data7_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       mp_en_i,
  input  logic       rxd_i,
  input  logic       read_i,
  input  logic       clr_i,
  output logic [7:0] data_o,
  output logic       mpb_o,
  output logic       valid_o,
  output logic       fer_o,
  output logic       per_o,
  output logic       oer_o,
  output logic       brk_o
);
  logic       rx_m, rx_s, rx_q;
  rx_state_e  state;
  logic [3:0] tick_cnt;
  logic [3:0] bit_idx;
  logic [8:0] rbits;
  logic [3:0] dlen, nrx;
  logic       extra, xbit, stop_bit, done, overrun;
  logic       brk_hit, per_hit;
  logic [7:0] data_rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_q <= 1'b1;
    end else begin
      rx_m <= rxd_i;
      rx_s <= rx_m;
      rx_q <= rx_s;
    end
  end

  always_comb begin
    dlen     = data7_i ? 4'd7 : 4'd8;
    extra    = par_en_i | mp_en_i;
    nrx      = dlen + {3'b0, extra};
    data_rx  = data7_i ? {1'b0, rbits[6:0]} : rbits[7:0];
    xbit     = rbits[dlen];
    stop_bit = rx_s;
    done     = (state == RX_BITS) && tick_i && (tick_cnt == 4'd15) && (bit_idx == nrx);
    overrun  = valid_o && !read_i;
    brk_hit  = (data_rx == 8'd0) && !(extra && xbit) && !stop_bit;
    per_hit  = par_en_i && !mp_en_i && (xbit != par_bit(data_rx, data7_i, par_odd_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= RX_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      rbits    <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (rx_q && !rx_s) begin
            state    <= RX_START;
            tick_cnt <= '0;
          end
        end
        RX_START: begin
          if (tick_i) begin
            tick_cnt <= tick_cnt + 4'd1;
            if (tick_cnt == 4'd7) begin
              if (!rx_s) begin
                state    <= RX_BITS;
                tick_cnt <= '0;
                bit_idx  <= '0;
              end else begin
                state <= RX_IDLE;
              end
            end
          end
        end
        RX_BITS: begin
          if (tick_i) begin
            tick_cnt <= tick_cnt + 4'd1;
            if (tick_cnt == 4'd15) begin
              if (bit_idx == nrx) begin
                state <= RX_IDLE;
              end else begin
                rbits[bit_idx] <= rx_s;
                bit_idx        <= bit_idx + 4'd1;
              end
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      mpb_o   <= 1'b0;
    end else begin
      if (read_i) valid_o <= 1'b0;
      if (done && !overrun) begin
        valid_o <= 1'b1;
        data_o  <= data_rx;
        mpb_o   <= mp_en_i & xbit;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fer_o <= 1'b0;
      per_o <= 1'b0;
      oer_o <= 1'b0;
      brk_o <= 1'b0;
    end else begin
      if (clr_i) begin
        fer_o <= 1'b0;
        per_o <= 1'b0;
        oer_o <= 1'b0;
        brk_o <= 1'b0;
      end
      if (done) begin
        if (overrun) begin
          oer_o <= 1'b1;
        end else begin
          if (!stop_bit) fer_o <= 1'b1;
          if (per_hit)   per_o <= 1'b1;
          if (brk_hit)   brk_o <= 1'b1;
        end
      end
    end
  end

  p_overrun_keeps_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !read_i |=> $stable(data_o));

  p_break_framing_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_o) |-> fer_o);

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && read_i && !done |=> !valid_o);

  p_flags_clear_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !done |=> !fer_o && !per_o && !oer_o && !brk_o);

endmodule

// File: rtl/async_serial_ctrl.sv
module async_serial_ctrl
  import async_serial_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int PSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PSEL_W-1:0] presc_sel_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              data7_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              mp_en_i,
  input  logic              stop2_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_mpb_i,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rx_valid_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_mpb_o,
  input  logic              rx_read_i,
  output logic              fer_o,
  output logic              per_o,
  output logic              oer_o,
  output logic              brk_o,
  input  logic              clr_err_i
);
  logic       tick;
  frame_cfg_t cfg;

  assign cfg = '{data7: data7_i, par_en: parity_en_i, par_odd: parity_odd_i,
                 mp_en: mp_en_i, stop2: stop2_i};

  baud_tick_gen #(.DIV_W(DIV_W), .PSEL_W(PSEL_W)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (presc_sel_i),
    .divisor_i (divisor_i),
    .tick_o    (tick)
  );

  async_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .cfg_i   (cfg),
    .valid_i (tx_valid_i),
    .data_i  (tx_data_i),
    .mpb_i   (tx_mpb_i),
    .ready_o (tx_ready_o),
    .txd_o   (txd_o)
  );

  async_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .data7_i   (data7_i),
    .par_en_i  (parity_en_i),
    .par_odd_i (parity_odd_i),
    .mp_en_i   (mp_en_i),
    .rxd_i     (rxd_i),
    .read_i    (rx_read_i),
    .clr_i     (clr_err_i),
    .data_o    (rx_data_o),
    .mpb_o     (rx_mpb_o),
    .valid_o   (rx_valid_o),
    .fer_o     (fer_o),
    .per_o     (per_o),
    .oer_o     (oer_o),
    .brk_o     (brk_o)
  );

endmodule

// File: tb/async_serial_ctrl_tb_top.sv
`timescale 1ns/1ps
module async_serial_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] presc_sel_i = 2'd0;
  logic [7:0] divisor_i = 8'd0;
  logic       data7_i = 1'b0, parity_en_i = 1'b0, parity_odd_i = 1'b0;
  logic       mp_en_i = 1'b0, stop2_i = 1'b0;
  logic       tx_valid_i = 1'b0, tx_mpb_i = 1'b0;
  logic [7:0] tx_data_i = 8'd0;
  logic       tx_ready_o, txd_o;
  logic       rxd_i = 1'b1, rx_read_i = 1'b0, clr_err_i = 1'b0;
  logic       rx_valid_o, rx_mpb_o, fer_o, per_o, oer_o, brk_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  async_serial_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .presc_sel_i(presc_sel_i), .divisor_i(divisor_i),
    .data7_i(data7_i), .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
    .mp_en_i(mp_en_i), .stop2_i(stop2_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .tx_data_i(tx_data_i), .tx_mpb_i(tx_mpb_i), .txd_o(txd_o), .rxd_i(rxd_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_mpb_o(rx_mpb_o),
    .rx_read_i(rx_read_i), .fer_o(fer_o), .per_o(per_o), .oer_o(oer_o),
    .brk_o(brk_o), .clr_err_i(clr_err_i)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic d7, input logic pe, input logic po,
                         input logic me, input logic s2);
    @(negedge clk_i);
    data7_i = d7; parity_en_i = pe; parity_odd_i = po; mp_en_i = me; stop2_i = s2;
  endtask

  // start a transmission; returns at the first negedge after acceptance
  task automatic tx_begin(input logic [7:0] d, input logic mpb);
    while (!tx_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    tx_data_i = d; tx_mpb_i = mpb; tx_valid_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    chk("R7 ready low after accept", int'(tx_ready_o), 0);
    chk("R7 start bit low after accept", int'(txd_o), 0);
  endtask

  // sample n slot centres (32-cycle bits), then the slot after
  task automatic tx_capture(input int n, output logic [11:0] got,
                            output logic rdy_after, output logic line_after);
    got = '0;
    repeat (16) @(negedge clk_i);
    got[0] = txd_o;
    for (int i = 1; i < n; i++) begin
      repeat (32) @(negedge clk_i);
      got[i] = txd_o;
    end
    repeat (32) @(negedge clk_i);
    rdy_after  = tx_ready_o;
    line_after = txd_o;
  endtask

  task automatic rx_frame(input logic [11:0] b, input int n);
    @(negedge clk_i);
    for (int i = 0; i < n; i++) begin
      rxd_i = b[i];
      repeat (32) @(negedge clk_i);
    end
    rxd_i = 1'b1;
    repeat (40) @(negedge clk_i);
  endtask

  task automatic pulse_read;
    rx_read_i = 1'b1;
    @(negedge clk_i);
    rx_read_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic pulse_clr;
    clr_err_i = 1'b1;
    @(negedge clk_i);
    clr_err_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1 txd idle high", int'(txd_o), 1);
    chk("R1 tx ready", int'(tx_ready_o), 1);
    chk("R1 rx valid low", int'(rx_valid_o), 0);
    chk("R1 flags low", int'({fer_o, per_o, oer_o, brk_o}), 0);
  endtask

  task automatic t_tx_8n1;
    logic [11:0] got; logic rdy, ln;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tx_begin(8'hA5, 1'b0);
    tx_capture(10, got, rdy, ln);
    chk("R3 8N1 frame A5", int'(got), int'({2'b0, 1'b1, 8'hA5, 1'b0}));
    chk("R6 one stop ready back", int'(rdy), 1);
    chk("R6 one stop line idle", int'(ln), 1);
  endtask

  task automatic t_tx_parity;
    logic [11:0] got; logic rdy, ln;
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    tx_begin(8'h5A, 1'b0);
    tx_capture(10, got, rdy, ln);
    chk("R4 7E1 frame 5A", int'(got), int'({2'b0, 1'b1, 1'b0, 7'h5A, 1'b0}));
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    tx_begin(8'hB5, 1'b0);
    tx_capture(10, got, rdy, ln);
    chk("R3 R4 7O1 frame, bit7 dropped", int'(got), int'({2'b0, 1'b1, 1'b1, 7'h35, 1'b0}));
  endtask

  task automatic t_tx_mp_2stop;
    logic [11:0] got; logic rdy, ln;
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    tx_begin(8'h81, 1'b1);
    tx_capture(11, got, rdy, ln);
    chk("R5 mp bit frame 81", int'(got), int'({1'b0, 1'b1, 1'b1, 8'h81, 1'b0}));
    chk("R6 ready low in 2nd stop", int'(rdy), 0);
    chk("R6 2nd stop high", int'(ln), 1);
  endtask

  task automatic t_baud(input logic [1:0] ps, input logic [7:0] dv, input int lo, input int hi);
    int cnt;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    presc_sel_i = ps; divisor_i = dv;
    tx_begin(8'hFE, 1'b0);
    cnt = 1;
    while (txd_o == 1'b0 && cnt < 10000) begin
      @(negedge clk_i);
      cnt++;
    end
    chk("R2 two-bit low time in window", int'(cnt >= lo && cnt <= hi), 1);
    if (cnt < lo || cnt > hi) $display("  low time %0d cycles", cnt);
    while (!tx_ready_o) @(negedge clk_i);
    presc_sel_i = 2'd0; divisor_i = 8'd0;
  endtask

  task automatic t_rx_basic;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_frame({2'b0, 1'b1, 8'h3C, 1'b0}, 10);
    chk("R8 rx valid", int'(rx_valid_o), 1);
    chk("R8 rx data 3C", int'(rx_data_o), 'h3C);
    chk("R8 no flags", int'({fer_o, per_o, oer_o, brk_o}), 0);
    pulse_read;
    chk("R8 valid dropped after read", int'(rx_valid_o), 0);
  endtask

  task automatic t_rx_mp;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    rx_frame({1'b0, 1'b1, 1'b1, 8'h42, 1'b0}, 11);
    chk("R5 rx mp bit", int'(rx_mpb_o), 1);
    chk("R5 rx mp data", int'(rx_data_o), 'h42);
    pulse_read;
  endtask

  task automatic t_rx_parity;
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    rx_frame({2'b0, 1'b1, 1'b0, 7'h07, 1'b0}, 10);
    chk("R11 parity error set", int'(per_o), 1);
    chk("R11 no framing error", int'(fer_o), 0);
    chk("R8 7-bit data", int'(rx_data_o), 'h07);
    pulse_read;
    chk("R14 parity flag sticky after read", int'(per_o), 1);
    pulse_clr;
    chk("R14 clear drops flags", int'({fer_o, per_o, oer_o, brk_o}), 0);
  endtask

  task automatic t_rx_framing;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_frame({2'b0, 1'b0, 8'h55, 1'b0}, 10);
    chk("R10 framing error", int'(fer_o), 1);
    chk("R10 not a break", int'(brk_o), 0);
    pulse_read;
    pulse_clr;
  endtask

  task automatic t_rx_break;
    rx_frame(12'h000, 10);
    chk("R12 break flag", int'(brk_o), 1);
    chk("R12 break also framing", int'(fer_o), 1);
    chk("R12 break data zero", int'(rx_data_o), 0);
    pulse_read;
    pulse_clr;
    chk("R14 flags clear after break", int'({fer_o, per_o, oer_o, brk_o}), 0);
  endtask

  task automatic t_rx_glitch;
    @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (6) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (400) @(negedge clk_i);
    chk("R9 glitch ignored", int'(rx_valid_o), 0);
    chk("R9 glitch no flags", int'({fer_o, per_o, oer_o, brk_o}), 0);
  endtask

  task automatic t_rx_overrun;
    rx_frame({2'b0, 1'b1, 8'h11, 1'b0}, 10);
    rx_frame({2'b0, 1'b1, 8'h22, 1'b0}, 10);
    chk("R13 overrun flag", int'(oer_o), 1);
    chk("R13 old data kept", int'(rx_data_o), 'h11);
    chk("R13 still valid", int'(rx_valid_o), 1);
    pulse_read;
    chk("R13 valid dropped after read", int'(rx_valid_o), 0);
    pulse_clr;
    chk("R14 overrun cleared", int'(oer_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_tx_8n1;
    t_tx_parity;
    t_tx_mp_2stop;
    t_baud(2'd1, 8'd1, 490, 520);
    t_baud(2'd3, 8'd0, 3950, 4100);
    t_rx_basic;
    t_rx_mp;
    t_rx_parity;
    t_rx_framing;
    t_rx_break;
    t_rx_glitch;
    t_rx_overrun;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule